// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a bus-mapped interval timer that produces a regular tick for an operating system and also acts as a free-running time base. The system clock passes through a divide-by-16 prescaler. Each prescaled tick advances a 20-bit interval counter. When that counter reaches the programmed limit, it returns to zero on the next tick. Each such return raises a status flag and bumps a 12-bit overflow counter. Software reads the current time as the overflow count times the period, plus the interval counter.

There are two read-only views of the counters, and they share one layout. The acknowledge view at offset 0x08 clears the flag and the overflow count as it is read. The image view at offset 0x0C leaves all state alone. The interrupt line is the flag masked by an enable. Turning the timer off does not freeze it: the counter runs on to its next return to zero and then stops there.

Top module: `tick_timer`

## Requirements
- R1: While the timer runs, the interval counter advances by one every 16 clock cycles. After the timer is enabled from the idle state, the first increment lands on the 16th rising edge after the write edge.
- R2: The interval counter returns to zero on the tick that finds it at or above the limit in mode bits 19:0. The period is therefore (limit+1)×16 clocks.
- R3: Bit 0 of the status word at offset 0x04 becomes 1 on the edge where the interval counter returns to zero. The other bits of the status word read as zero.
- R4: Offsets 0x08 and 0x0C both return the overflow count in bits 31:20 and the interval counter in bits 19:0. The overflow count rises by one on every return to zero and wraps modulo 4096.
- R5: A read of offset 0x0C changes no state.
- R6: A read of offset 0x08 returns the values held before the read. On that edge it clears the status flag and sets the overflow count to zero. If a return to zero falls on the same edge, the overflow count becomes 1 and the flag stays set.
- R7: The irq output is high exactly when the status flag and the interrupt enable (mode bit 25) are both 1. It is a level, and it stays high until a read of 0x08 or a clear of the enable.
- R8: Clearing the run enable (mode bit 24) lets the counter go on ticking until it returns to zero, which also sets the flag. The counter then holds at zero.
- R9: After reset, every register, the counters and irq are zero. Writes to offsets 0x04, 0x08 and 0x0C have no effect.
- R10: Offset 0x00 reads back the last written limit (bits 19:0), run enable (bit 24) and interrupt enable (bit 25). All other bits of that word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid during the strobe cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The checks assume the following about the inputs:
- Every access is a single-cycle strobe to one of the four defined offsets.
- Software never lowers the limit below the interval counter's current value while the timer runs, so the counter only climbs, returns to zero, or rests.
- A read of offset 0x08 is the only event besides reset that lowers the flag or resets the overflow count.

The stimulus keeps to these rules. It issues isolated one-cycle accesses. It changes only the two enable bits mid-run, with the limit held fixed. Then it switches to a limit of zero, only after the counter has drained to rest. Each read is scheduled on an absolute edge count from the first enable, so that one acknowledge lands exactly on a return to zero.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Register byte offsets
   localparam int OFF_MODE = 'h0;
   localparam int OFF_STAT = 'h4;
   localparam int OFF_VAL  = 'h8;
   localparam int OFF_IMG  = 'hC;
   localparam int MIN_ADDR_W = 4;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = active;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) pre_q <= '0;
            else if (pre_q == LAST) pre_q <= '0;
            else pre_q <= pre_q + 1'b1;
         end
         assign tick = active && (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pit_count.sv
module pit_count #(
   parameter int CNT_W = 20,
   parameter int OVF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   input  logic             ack,
   output logic [CNT_W-1:0] cnt,
   output logic [OVF_W-1:0] ovf,
   output logic             wrap
);
   assign wrap = tick && (cnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (wrap) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   // acknowledge restarts the count; a coinciding wrap is kept as one
   always_ff @(posedge clk) begin
      if (!rst_n) ovf <= '0;
      else if (ack) ovf <= wrap ? OVF_W'(1) : '0;
      else if (wrap) ovf <= ovf + 1'b1;
   end
endmodule

// File: rtl/pit_regs.sv
module pit_regs #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 20,
   parameter int OVF_W  = 12,
   parameter int EN_BIT = 24,
   parameter int IE_BIT = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [OVF_W-1:0]  ovf,
   input  logic              wrap,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CNT_W-1:0]  limit,
   output logic              run_en,
   output logic              int_en,
   output logic              status,
   output logic              ack
);
   import pit_pkg::*;

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFF_VAL);
   localparam logic [ADDR_W-1:0] A_IMG  = ADDR_W'(OFF_IMG);

   logic mode_wr;
   logic unused_wd;

   assign unused_wd = ^bus_wdata;
   assign mode_wr   = bus_en && bus_we && (bus_addr == A_MODE);
   assign ack       = bus_en && !bus_we && (bus_addr == A_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit  <= '0;
         run_en <= 1'b0;
         int_en <= 1'b0;
      end else if (mode_wr) begin
         limit  <= bus_wdata[CNT_W-1:0];
         run_en <= bus_wdata[EN_BIT];
         int_en <= bus_wdata[IE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) status <= 1'b0;
      else if (wrap) status <= 1'b1;
      else if (ack) status <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MODE: begin
            bus_rdata[CNT_W-1:0] = limit;
            bus_rdata[EN_BIT]    = run_en;
            bus_rdata[IE_BIT]    = int_en;
         end
         A_STAT:        bus_rdata[0] = status;
         A_VAL, A_IMG:  bus_rdata = {ovf, cnt};
         default:       bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 20,
   parameter int OVF_W    = 12,
   parameter int PRESCALE = 16,
   parameter int EN_BIT   = 24,
   parameter int IE_BIT   = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W + OVF_W != DATA_W) begin : g_bad_width
         $error("counter fields must fill the data word");
      end
      if (EN_BIT < CNT_W || IE_BIT < CNT_W || EN_BIT == IE_BIT ||
          EN_BIT >= DATA_W || IE_BIT >= DATA_W) begin : g_bad_bits
         $error("enable bits overlap the limit field or leave the word");
      end
      if (ADDR_W < pit_pkg::MIN_ADDR_W) begin : g_bad_addr
         $error("address too narrow for the register map");
      end
      if (PRESCALE < 1) begin : g_bad_div
         $error("prescale must be at least one");
      end
   endgenerate

   logic             tick_w;
   logic             active_w;
   logic             wrap_w;
   logic             ack_w;
   logic             run_en_w;
   logic             int_en_w;
   logic             status_w;
   logic [CNT_W-1:0] limit_w;
   logic [CNT_W-1:0] cnt_w;
   logic [OVF_W-1:0] ovf_w;

   // keeps running after disable until the counter rests at zero
   assign active_w = run_en_w || (cnt_w != '0);
   assign irq      = status_w && int_en_w;

   pit_prescale #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .active(active_w), .tick(tick_w)
   );

   pit_count #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .limit(limit_w),
      .ack(ack_w), .cnt(cnt_w), .ovf(ovf_w), .wrap(wrap_w)
   );

   pit_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OVF_W(OVF_W),
      .EN_BIT(EN_BIT), .IE_BIT(IE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_w), .ovf(ovf_w),
      .wrap(wrap_w), .bus_rdata(bus_rdata), .limit(limit_w),
      .run_en(run_en_w), .int_en(int_en_w), .status(status_w), .ack(ack_w)
   );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W = 20,
   parameter int OVF_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt,
   input logic [OVF_W-1:0] ovf,
   input logic             status,
   input logic             ack,
   input logic             en,
   input logic             ie,
   input logic             irq
);
   // R1: counter only steps by one or returns to zero
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == '0));

   // R3: leaving a nonzero count for zero raises the flag
   a_r3_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> (cnt != '0 || status));

   // R4: overflow count only increments or restarts
   a_r4_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf != $past(ovf)) |-> (ovf == $past(ovf) + 1'b1 || ovf <= OVF_W'(1)));

   // R6: after an acknowledge at most the coinciding wrap remains
   a_r6_ack_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (ovf <= OVF_W'(1)));

   // R5: only the acknowledging read lowers the flag
   a_r5_only_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !ack) |=> status);

   // R7: the request is a level held until acknowledge or mask
   a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> (irq || !ie));

   // R8: a disabled timer at rest stays at rest
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && cnt == '0) |=> (cnt == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .ovf(ovf_w), .status(status_w),
   .ack(ack_w), .en(run_en_w), .ie(int_en_w), .irq(irq)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int t0 = 0;
   int last_wr = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tick_timer u_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data during each read strobe
   always @(negedge clk) begin
      if (bus_en && !bus_we) begin
         if (exp_q.size() == 0) check("scoreboard underrun", 32'h1, 32'h0);
         else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   // all driver tasks start just after a rising edge
   task automatic rd(input logic [3:0] a, input logic [31:0] exp,
                     input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      last_wr = cyc;
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      @(negedge clk);
      check(tag, {31'b0, irq}, {31'b0, exp});
      @(posedge clk); #1;
   endtask

   task automatic goto(input int k);
      while (cyc < t0 + k) begin
         @(posedge clk); #1;
      end
   endtask

   function automatic logic [31:0] cv(input int o, input int c);
      return {o[11:0], c[19:0]};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      check("watchdog expired", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R9 reset state
      rd(4'h0, 32'h0, "R9 mode after reset");
      rd(4'h4, 32'h0, "R9 status after reset");
      rd(4'h8, 32'h0, "R9 value after reset");
      rd(4'hC, 32'h0, "R9 image after reset");
      chk_irq(1'b0, "R9 irq after reset");

      wr(4'h0, 32'h0100_0003);     // limit 3, run, no interrupt
      t0 = last_wr;
      goto(40);  rd(4'hC, cv(0, 2), "R1 two ticks in 40 clocks");
      goto(63);  rd(4'hC, cv(0, 3), "R2 count at limit before wrap");
      goto(64);  rd(4'h4, 32'h1,    "R3 flag at wrap");
      goto(65);  rd(4'hC, cv(1, 0), "R4 one overflow, count zero");
      goto(66);  rd(4'hC, cv(1, 0), "R5 image read repeatable");
      goto(67);  rd(4'h4, 32'h1,    "R5 flag kept after image read");
      goto(68);  chk_irq(1'b0,      "R7 masked irq stays low");
      goto(70);  rd(4'h8, cv(1, 0), "R6 value read returns held state");
      goto(71);  rd(4'h4, 32'h0,    "R6 flag cleared by value read");
      goto(72);  rd(4'hC, cv(0, 0), "R6 overflow cleared by value read");
      goto(260); rd(4'hC, cv(3, 0), "R4 three further wraps counted");
      goto(262); wr(4'h0, 32'h0300_0003);
      chk_irq(1'b1, "R7 enable exposes pending flag");
      goto(319); rd(4'h8, cv(3, 3), "R6 value read on wrap edge");
      goto(320); rd(4'hC, cv(1, 0), "R6 coinciding wrap kept as one");
      goto(321); rd(4'h4, 32'h1,    "R6 flag kept on coinciding wrap");
      goto(330); rd(4'h8, cv(1, 0), "R6 second acknowledge");
      goto(331); chk_irq(1'b0,      "R7 irq dropped by acknowledge");
      goto(340); wr(4'h0, 32'h0200_0003);   // stop running, keep interrupt
      goto(342); rd(4'h0, 32'h0200_0003, "R10 mode readback");
      goto(360); rd(4'hC, cv(0, 2), "R8 still counting after disable");
      goto(500); rd(4'hC, cv(1, 0), "R8 drained to zero with wrap");
      goto(510); chk_irq(1'b1,      "R7 drain wrap raises irq");
      goto(520); rd(4'hC, cv(1, 0), "R8 held at zero");
      goto(530); wr(4'h4, 32'hFFFF_FFFF);
      goto(532); wr(4'h8, 32'hFFFF_FFFF);
      goto(534); wr(4'hC, 32'hFFFF_FFFF);
      goto(536); rd(4'h4, 32'h1,    "R9 status write ignored");
      goto(537); rd(4'hC, cv(1, 0), "R9 value and image writes ignored");
      goto(540); wr(4'h0, 32'hFCF0_0003);
      goto(542); rd(4'h0, 32'h0000_0003, "R10 undefined mode bits read zero");
      goto(543); chk_irq(1'b0,      "R7 mask clear drops irq");
      goto(550); rd(4'h8, cv(1, 0), "R6 acknowledge before long run");
      goto(560); wr(4'h0, 32'h0100_0000);   // limit 0: wrap every tick
      goto(561 + 16 * 4095 + 3); rd(4'hC, cv(4095, 0), "R4 overflow at 4095");
      goto(561 + 16 * 4097 + 5); rd(4'hC, cv(1, 0),    "R4 overflow wraps modulo 4096");
      @(posedge clk); #1;
      if (exp_q.size() != 0) check("scoreboard leftover", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule